// File: doc/BRIEF.md
# Pipelined Block Rotator

This block takes a wide word made of `BLOCKS` lanes, each `BLK_W` bits wide, and rotates it by a whole number of lanes. The rotation amount arrives with the word on `in_sel`. The direction is fixed when the block is built, through the `ROT_LEFT` parameter. Lanes that leave one end of the word come back in at the other end. Nothing is zero-filled, and no bit moves within a lane.

The rotation network is logarithmic. It has one level for each select bit, and the level for bit k moves the word by 2^k lanes when that bit is set. `STAGES` pipeline slots are spread evenly among these levels. Two further slots are optional: `IN_REG` places one ahead of the network and `OUT_REG` places one behind it. Every slot is a two-state machine with the states SLOT_EMPTY and SLOT_FULL. A slot moves between them on four named transitions:

- fill: SLOT_EMPTY to SLOT_FULL, when the upstream side offers a word.
- hold: SLOT_FULL to SLOT_FULL with the contents kept, while downstream is not ready.
- refill: SLOT_FULL to SLOT_FULL with a new word loaded, when downstream takes the old word and upstream offers another.
- drain: SLOT_FULL to SLOT_EMPTY, when downstream takes the word and nothing new arrives.

A sideband word `in_meta` rides in the same slots as its data and comes out next to it. A typical use is to forward the applied select. When `META_W` is 0, the sideband is one bit wide and is still carried. With no slots at all, the block is a purely combinational path, and clock and reset have no effect.

Top module: `brot_top`

## Requirements
- R1: With `ROT_LEFT`=0, output lane i (bits i*BLK_W upward) equals input lane (i+sel) mod BLOCKS of the word that was accepted with that select.
- R2: With `ROT_LEFT`=1, output lane i equals input lane (i-sel) mod BLOCKS.
- R3: A select of 0 delivers the word unchanged.
- R4: When `out_ready` stays high, a word accepted at one rising edge appears on `out_valid` after exactly STAGES+IN_REG+OUT_REG rising edges, counting the accepting edge.
- R5: When STAGES=0 and both registers are off, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the data and sideband pass through in the same cycle.
- R6: `out_meta` shows the sideband value that was accepted together with the word now on `out_data`.
- R7: Under any pattern of `out_ready`, every accepted word leaves exactly once and in acceptance order. In every cycle where `out_ready` is high, `in_ready` is also high.
- R8: A synchronous active-high `rst` empties every slot. In the cycle after reset is released, `out_valid` is 0 and `in_ready` is 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_meta` hold their values into the next cycle.
- R10: With BLOCKS=1, the select is ignored and the word passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | BLOCKS*BLK_W | Word to rotate |
| in_sel | input | max(1,log2 BLOCKS) | Rotation amount in lanes |
| in_meta | input | max(1,META_W) | Sideband carried with the word |
| out_valid | output | 1 | A rotated word is present |
| out_ready | input | 1 | Downstream takes the word this cycle |
| out_data | output | BLOCKS*BLK_W | Rotated word |
| out_meta | output | max(1,META_W) | Sideband of the word on out_data |

## Verification
The bound checker watches the output handshake on every cycle. It checks that a stalled output word stays frozen, that reset leaves the output empty, that readiness at the output always reaches the input, and that every level of the network has consumed its select bit before a word leaves. In the slot-free build, it checks that valid and ready pass straight through. Only the bench scenarios can show the lane mapping for each select and direction, the exact latency, and the pairing of sideband with data. The same holds for the absence of loss, duplication or reordering under random backpressure.

// File: rtl/brot_pkg.sv
`timescale 1ns/1ps
package brot_pkg;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    function automatic int sel_width(input int blocks);
        return (blocks > 1) ? $clog2(blocks) : 1;
    endfunction

    function automatic int level_count(input int blocks);
        return (blocks > 1) ? $clog2(blocks) : 0;
    endfunction

    function automatic int side_width(input int mw);
        return (mw > 0) ? mw : 1;
    endfunction

endpackage

// File: rtl/brot_slot.sv
`timescale 1ns/1ps
// One elastic pipeline slot: holds a payload and its valid state.
module brot_slot
    import brot_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [PW-1:0] up_pl,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [PW-1:0] dn_pl
);

    slot_state_e st_q, st_d;
    logic        load;
    logic [PW-1:0] pl_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= SLOT_EMPTY;
        else     st_q <= st_d;
    end

    // transitions and handshake outputs
    always_comb begin
        st_d     = st_q;
        load     = 1'b0;
        up_ready = 1'b0;
        dn_valid = 1'b0;
        unique case (st_q)
            SLOT_EMPTY: begin
                up_ready = 1'b1;
                if (up_valid) begin          // fill
                    load = 1'b1;
                    st_d = SLOT_FULL;
                end
            end
            SLOT_FULL: begin
                dn_valid = 1'b1;
                up_ready = dn_ready;
                if (dn_ready) begin
                    if (up_valid) load = 1'b1;   // refill
                    else          st_d = SLOT_EMPTY; // drain
                end                          // else hold
            end
        endcase
    end

    // payload register, no reset needed
    always_ff @(posedge clk) begin
        if (load) pl_q <= up_pl;
    end

    assign dn_pl = pl_q;

endmodule

// File: rtl/brot_level.sv
`timescale 1ns/1ps
// One level of the logarithmic rotator: moves by 2**LVL lanes when its select bit is set.
module brot_level #(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = 4,
    parameter int SEL_W  = 3,
    parameter int LVL    = 0,
    parameter bit LEFT   = 1'b0
) (
    input  logic [BLOCKS*BLK_W-1:0] in_data,
    input  logic [SEL_W-1:0]        in_sel,
    output logic [BLOCKS*BLK_W-1:0] out_data,
    output logic [SEL_W-1:0]        out_sel
);

    localparam int SH = (1 << LVL) % BLOCKS;

    for (genvar i = 0; i < BLOCKS; i++) begin : g_lane
        localparam int SRC = LEFT ? ((i + BLOCKS - SH) % BLOCKS) : ((i + SH) % BLOCKS);
        assign out_data[i*BLK_W +: BLK_W] = in_sel[LVL] ? in_data[SRC*BLK_W +: BLK_W]
                                                        : in_data[i*BLK_W +: BLK_W];
    end

    // the consumed bit is cleared so the residue reaching the output is zero
    always_comb begin
        out_sel      = in_sel;
        out_sel[LVL] = 1'b0;
    end

endmodule

// File: rtl/brot_top.sv
`timescale 1ns/1ps
module brot_top
    import brot_pkg::*;
#(
    parameter int BLOCKS   = 256,
    parameter int BLK_W    = 64,
    parameter int STAGES   = 0,
    parameter bit IN_REG   = 1'b0,
    parameter bit OUT_REG  = 1'b0,
    parameter bit ROT_LEFT = 1'b0,
    parameter int META_W   = 0
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [BLOCKS*BLK_W-1:0]           in_data,
    input  logic [sel_width(BLOCKS)-1:0]      in_sel,
    input  logic [side_width(META_W)-1:0]     in_meta,
    output logic                              out_valid,
    input  logic                              out_ready,
    output logic [BLOCKS*BLK_W-1:0]           out_data,
    output logic [side_width(META_W)-1:0]     out_meta
);

    localparam int DW        = BLOCKS * BLK_W;
    localparam int SEL_W     = sel_width(BLOCKS);
    localparam int MW        = side_width(META_W);
    localparam int LEVELS    = level_count(BLOCKS);
    localparam int TOTAL     = LEVELS + STAGES;
    localparam int PW        = DW + SEL_W + MW;
    localparam int LAT_TOTAL = STAGES + int'(IN_REG) + int'(OUT_REG);

    logic [SEL_W-1:0] ent_sel;
    logic [DW-1:0]    nd_data [0:TOTAL];
    logic [SEL_W-1:0] nd_sel  [0:TOTAL];
    logic [MW-1:0]    nd_meta [0:TOTAL];
    logic             nd_v    [0:TOTAL];
    logic             nd_r    [0:TOTAL];
    logic [SEL_W-1:0] o_sel;
    logic [SEL_W-1:0] tail_sel;

    // a single lane has nothing to rotate
    if (BLOCKS > 1) begin : g_sel
        assign ent_sel = in_sel;
    end else begin : g_nosel
        assign ent_sel = '0;
    end

    // entry stage
    if (IN_REG) begin : g_inreg
        logic [PW-1:0] q;
        brot_slot #(.PW(PW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .up_valid (in_valid),
            .up_ready (in_ready),
            .up_pl    ({in_meta, ent_sel, in_data}),
            .dn_valid (nd_v[0]),
            .dn_ready (nd_r[0]),
            .dn_pl    (q)
        );
        assign nd_data[0] = q[DW-1:0];
        assign nd_sel[0]  = q[DW +: SEL_W];
        assign nd_meta[0] = q[DW+SEL_W +: MW];
    end else begin : g_inpass
        assign nd_v[0]    = in_valid;
        assign in_ready   = nd_r[0];
        assign nd_data[0] = in_data;
        assign nd_sel[0]  = ent_sel;
        assign nd_meta[0] = in_meta;
    end

    // network: LEVELS levels with STAGES slots interleaved evenly
    for (genvar e = 0; e < TOTAL; e++) begin : g_el
        localparam int CUT_NOW  = ((e + 1) * STAGES) / TOTAL;
        localparam int CUT_PREV = (e * STAGES) / TOTAL;
        if (CUT_NOW != CUT_PREV) begin : g_slot
            logic [PW-1:0] q;
            brot_slot #(.PW(PW)) u_slot (
                .clk      (clk),
                .rst      (rst),
                .up_valid (nd_v[e]),
                .up_ready (nd_r[e]),
                .up_pl    ({nd_meta[e], nd_sel[e], nd_data[e]}),
                .dn_valid (nd_v[e+1]),
                .dn_ready (nd_r[e+1]),
                .dn_pl    (q)
            );
            assign nd_data[e+1] = q[DW-1:0];
            assign nd_sel[e+1]  = q[DW +: SEL_W];
            assign nd_meta[e+1] = q[DW+SEL_W +: MW];
        end else begin : g_lvl
            brot_level #(
                .BLOCKS (BLOCKS),
                .BLK_W  (BLK_W),
                .SEL_W  (SEL_W),
                .LVL    (e - CUT_PREV),
                .LEFT   (ROT_LEFT)
            ) u_lvl (
                .in_data  (nd_data[e]),
                .in_sel   (nd_sel[e]),
                .out_data (nd_data[e+1]),
                .out_sel  (nd_sel[e+1])
            );
            assign nd_meta[e+1] = nd_meta[e];
            assign nd_v[e+1]    = nd_v[e];
            assign nd_r[e]      = nd_r[e+1];
        end
    end

    // exit stage
    if (OUT_REG) begin : g_outreg
        logic [PW-1:0] q;
        brot_slot #(.PW(PW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .up_valid (nd_v[TOTAL]),
            .up_ready (nd_r[TOTAL]),
            .up_pl    ({nd_meta[TOTAL], nd_sel[TOTAL], nd_data[TOTAL]}),
            .dn_valid (out_valid),
            .dn_ready (out_ready),
            .dn_pl    (q)
        );
        assign out_data = q[DW-1:0];
        assign o_sel    = q[DW +: SEL_W];
        assign out_meta = q[DW+SEL_W +: MW];
    end else begin : g_outpass
        assign out_valid    = nd_v[TOTAL];
        assign nd_r[TOTAL]  = out_ready;
        assign out_data     = nd_data[TOTAL];
        assign o_sel        = nd_sel[TOTAL];
        assign out_meta     = nd_meta[TOTAL];
    end

    // residual select at the exit, observed by the bound checker
    assign tail_sel = o_sel;

endmodule

// File: rtl/brot_checker.sv
`timescale 1ns/1ps
module brot_checker #(
    parameter int LAT   = 0,
    parameter int DW    = 8,
    parameter int MW    = 1,
    parameter int SEL_W = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [DW-1:0]    out_data,
    input logic [MW-1:0]    out_meta,
    input logic [SEL_W-1:0] fin_sel
);

    // every level must have applied its select bit before a word leaves (R1, R2)
    assert_sel_consumed_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (fin_sel == '0))
        else $error("select residue at output");

    if (LAT > 0) begin : g_seq
        assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_meta)))
            else $error("stalled output changed");

        assert_reset_empty_R8: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !out_valid)
            else $error("output valid right after reset");

        assert_ready_reach_R7: assert property (@(posedge clk) disable iff (rst)
            out_ready |-> in_ready)
            else $error("output ready did not reach input");
    end else begin : g_comb
        always_comb begin
            assert_pass_through_R5: assert ((out_valid == in_valid) && (in_ready == out_ready))
                else $error("combinational handshake mismatch");
        end
    end

endmodule

bind brot_top brot_checker #(
    .LAT   (LAT_TOTAL),
    .DW    (DW),
    .MW    (MW),
    .SEL_W (SEL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_meta  (out_meta),
    .fin_sel   (tail_sel)
);

// File: tb/brot_top_tb_top.sv
`timescale 1ns/1ps
module brot_top_tb_top;

    localparam int NB  = 8;
    localparam int BW  = 4;
    localparam int DW  = NB * BW;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rot(input logic [DW-1:0] d, input int s, input bit left);
        logic [DW-1:0] r;
        for (int i = 0; i < NB; i++) begin
            int src;
            src = left ? ((i - s + NB) % NB) : ((i + s) % NB);
            r[i*BW +: BW] = d[src*BW +: BW];
        end
        return r;
    endfunction

    // pipelined right rotator, 2 stages + in/out registers
    logic          a_vin = 1'b0, a_irdy, a_vout, a_rdy = 1'b1;
    logic [DW-1:0] a_din = '0, a_dout;
    logic [2:0]    a_sel = '0, a_min = '0, a_mout;

    brot_top #(.BLOCKS(NB), .BLK_W(BW), .STAGES(2), .IN_REG(1'b1), .OUT_REG(1'b1),
               .ROT_LEFT(1'b0), .META_W(3)) dut_i (
        .clk(clk), .rst(rst), .in_valid(a_vin), .in_ready(a_irdy), .in_data(a_din),
        .in_sel(a_sel), .in_meta(a_min), .out_valid(a_vout), .out_ready(a_rdy),
        .out_data(a_dout), .out_meta(a_mout));

    // combinational left rotator
    logic          b_vin = 1'b0, b_irdy, b_vout, b_rdy = 1'b0;
    logic [DW-1:0] b_din = '0, b_dout;
    logic [2:0]    b_sel = '0;
    logic          b_min = 1'b0, b_mout;

    brot_top #(.BLOCKS(NB), .BLK_W(BW), .STAGES(0), .IN_REG(1'b0), .OUT_REG(1'b0),
               .ROT_LEFT(1'b1), .META_W(0)) dut_l (
        .clk(clk), .rst(rst), .in_valid(b_vin), .in_ready(b_irdy), .in_data(b_din),
        .in_sel(b_sel), .in_meta(b_min), .out_valid(b_vout), .out_ready(b_rdy),
        .out_data(b_dout), .out_meta(b_mout));

    // single-lane build
    logic       c_vin = 1'b1, c_irdy, c_vout, c_rdy = 1'b1;
    logic [7:0] c_din = '0, c_dout;
    logic       c_sel = 1'b0, c_min = 1'b0, c_mout;

    brot_top #(.BLOCKS(1), .BLK_W(8), .STAGES(0), .IN_REG(1'b0), .OUT_REG(1'b0),
               .ROT_LEFT(1'b0), .META_W(0)) dut_one (
        .clk(clk), .rst(rst), .in_valid(c_vin), .in_ready(c_irdy), .in_data(c_din),
        .in_sel(c_sel), .in_meta(c_min), .out_valid(c_vout), .out_ready(c_rdy),
        .out_data(c_dout), .out_meta(c_mout));

    // scoreboard for dut_i
    logic [DW-1:0] exp_d[$];
    logic [2:0]    exp_m[$];
    logic [2:0]    exp_s[$];
    int sent = 0;
    int rcvd = 0;
    bit bp   = 1'b0;

    always @(negedge clk) begin
        if (!rst && a_vout && a_rdy) begin
            rcvd++;
            if (exp_d.size() == 0) begin
                chk(1'b0, "R7 unexpected word", 64'(a_dout), 64'h0);
            end else begin
                logic [DW-1:0] ed;
                logic [2:0]    em, es;
                ed = exp_d.pop_front();
                em = exp_m.pop_front();
                es = exp_s.pop_front();
                if (es == 3'd0) chk(a_dout == ed, "R3 zero select data", 64'(a_dout), 64'(ed));
                else            chk(a_dout == ed, "R1 right rotation data", 64'(a_dout), 64'(ed));
                chk(a_mout == em, "R6 sideband alignment", 64'(a_mout), 64'(em));
            end
        end
        if (!rst && a_vin && a_irdy) begin
            sent++;
            exp_d.push_back(rot(a_din, int'(a_sel), 1'b0));
            exp_m.push_back(a_min);
            exp_s.push_back(a_sel);
        end
    end

    // downstream readiness
    initial begin
        forever begin
            @(posedge clk);
            #1 a_rdy = bp ? 1'($urandom_range(0, 1)) : 1'b1;
        end
    end

    // called at posedge+1; returns at posedge+1 after acceptance
    task automatic send(input logic [DW-1:0] d, input logic [2:0] s, input logic [2:0] m);
        a_vin = 1'b1; a_din = d; a_sel = s; a_min = m;
        forever begin
            @(negedge clk);
            if (a_irdy) break;
        end
        @(posedge clk);
        #1 a_vin = 1'b0;
        if (bp) begin
            repeat ($urandom_range(0, 2)) begin
                @(posedge clk);
                #1;
            end
        end
    endtask

    task automatic drain();
        for (int k = 0; k < 2000 && rcvd < sent; k++) @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pattern(input int p, input int s);
        case (p)
            0: return 32'h76543210;
            1: return 32'hF0000000;
            2: return 32'h0000000A;
            3: return 32'hA5A5A5A5;
            4: return 32'h13579BDF;
            default: return DW'({$urandom()} ^ (s * 32'h9E3779B9));
        endcase
    endfunction

    initial begin
        // reset and its aftermath (R8)
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(a_vout == 1'b0, "R8 out_valid after reset", 64'(a_vout), 64'h0);
        chk(a_irdy == 1'b1, "R8 in_ready after reset", 64'(a_irdy), 64'h1);
        @(posedge clk);
        #1;

        // latency with no backpressure (R4)
        begin
            int lat;
            a_vin = 1'b1; a_din = 32'h76543210; a_sel = 3'd3; a_min = 3'd3;
            @(posedge clk);
            #1 a_vin = 1'b0;
            lat = 1;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (a_vout) break;
                @(posedge clk);
                lat++;
            end
            chk(lat == LAT, "R4 latency", 64'(lat), 64'(LAT));
            drain();
        end

        // sweep all selects without backpressure, then with it (R1 R3 R6 R7)
        for (int pass = 0; pass < 2; pass++) begin
            bp = (pass == 1);
            for (int s = 0; s < NB; s++) begin
                for (int p = 0; p < 7; p++) begin
                    send(pattern(p, s), 3'(s), 3'(s));
                end
            end
            drain();
            chk(rcvd == sent, "R7 no loss or duplication", 64'(rcvd), 64'(sent));
        end
        chk(exp_d.size() == 0, "R7 scoreboard empty", 64'(exp_d.size()), 64'h0);
        bp = 1'b0;

        // combinational left build, all selects (R2 R3 R5)
        for (int s = 0; s < NB; s++) begin
            for (int p = 0; p < 6; p++) begin
                logic [DW-1:0] e;
                b_din = pattern(p, s); b_sel = 3'(s); b_min = 1'(p);
                #1;
                e = rot(b_din, s, 1'b1);
                if (s == 0) chk(b_dout == e, "R3 zero select left", 64'(b_dout), 64'(e));
                else        chk(b_dout == e, "R2 left rotation data", 64'(b_dout), 64'(e));
                chk(b_mout == b_min, "R5 sideband pass-through", 64'(b_mout), 64'(b_min));
            end
        end
        for (int v = 0; v < 4; v++) begin
            b_vin = v[0]; b_rdy = v[1];
            #1;
            chk(b_vout == b_vin, "R5 valid pass-through", 64'(b_vout), 64'(b_vin));
            chk(b_irdy == b_rdy, "R5 ready pass-through", 64'(b_irdy), 64'(b_rdy));
        end

        // single lane ignores the select (R10)
        for (int d = 0; d < 256; d += 17) begin
            for (int s = 0; s < 2; s++) begin
                c_din = 8'(d); c_sel = 1'(s);
                #1;
                chk(c_dout == c_din, "R10 single lane pass", 64'(c_dout), 64'(c_din));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", rcvd, sent);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule